// File: doc/BRIEF.md
# Shifted-Operand Compare Flag Unit

This unit carries out a single-cycle compare between a 32-bit accumulator and a 32-bit product register. The product first passes through a programmable shifter: a positive mode value shifts it left with zeros filling the low bits, and a negative mode value shifts it right arithmetically, copying the sign bit into the high bits. The unit derives a negative flag, a zero flag and a carry flag from the difference between the accumulator and the shifted product. It has no path that writes either operand.

The negative flag reflects the true signed difference and does not take bit 31 of a wrapped 32-bit result. Subtracting 1 from the most negative value therefore reports a negative result. The carry flag uses the inverted-borrow convention. The compare is not repeatable. When it executes while a repeat is active, the unit raises a clear request for the repeat counter in the same cycle and updates the flags exactly once.

Top module: `cmpf_unit`

## Requirements
- R1: `op_match_o` is high, combinationally, exactly when `instr_i` equals 16'hFF59 (binary 1111 1111 0101 1001).
- R2: The flags take new values only at a rising clock edge where `exec_i` is high and `instr_i` matches the compare opcode. At every other edge they keep their values.
- R3: `shift_mode_i` is a 4-bit two's-complement value. Values 0 to 4 shift the product left by that many places with zero fill. Values -1 to -6 shift it right arithmetically by 1 to 6 places. Values 5, 6, 7, -7 and -8 apply no shift. Bits shifted out past bit 31 are lost.
- R4: `flag_n_o` is set when the difference (accumulator minus shifted product), with both taken as signed values and computed without overflow, is below zero. For example, 0x80000000 minus 0x00000001 sets it.
- R5: `flag_z_o` is set exactly when the accumulator equals the shifted product.
- R6: `flag_c_o` is cleared when the subtraction borrows and set otherwise. This is the same as setting it when the accumulator is greater than or equal to the shifted product as unsigned values.
- R7: `rpt_clear_o` is high, combinationally, exactly when `exec_i` and `rpt_active_i` are both high and `instr_i` matches the opcode. The flags still update only once, at that edge.
- R8: A synchronous, active-high `rst` clears all three flags at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 32 | Accumulator operand |
| prod_i | input | 32 | Product operand before shifting |
| shift_mode_i | input | 4 | Signed shift mode |
| instr_i | input | 16 | Instruction word under decode |
| exec_i | input | 1 | Execute strobe |
| rpt_active_i | input | 1 | A repeat is in progress |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero flag |
| flag_c_o | output | 1 | Registered carry (no-borrow) flag |
| op_match_o | output | 1 | Instruction word matches the compare opcode |
| rpt_clear_o | output | 1 | Request to clear the repeat counter |

## Verification
The repeat-counter clear and the flag update happen in the same cycle when a matching compare executes while a repeat is active. The bench produces this by driving the opcode with `exec_i` and `rpt_active_i` both high. It checks `rpt_clear_o` before the edge and compares the flags after the edge against a single compare result. It also holds `rpt_active_i` high for the following cycles with `exec_i` low or a different opcode, and checks that the clear request drops and the flags stay unchanged.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned MODE_W  = 4;
    localparam int unsigned INSTR_W = 16;
    localparam int unsigned MAX_LSH = 4;
    localparam int unsigned MAX_RSH = 6;

    localparam logic [INSTR_W-1:0] CMP_OPCODE = 16'hFF59;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0};

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2
    } shift_kind_e;

    // Classify a signed mode value into a shift direction.
    function automatic shift_kind_e classify_mode(input logic signed [MODE_W-1:0] m);
        int v;
        v = int'(m);
        if (v > 0 && v <= int'(MAX_LSH))
            return SH_LEFT;
        else if (v < 0 && -v <= int'(MAX_RSH))
            return SH_RIGHT;
        else
            return SH_NONE;
    endfunction

endpackage

// File: rtl/cmpf_decode.sv
module cmpf_decode
    import cmpf_pkg::*;
#(
    parameter int unsigned IW = INSTR_W,
    parameter logic [IW-1:0] OPC = CMP_OPCODE
) (
    input  logic [IW-1:0] instr_i,
    input  logic          exec_i,
    input  logic          rpt_active_i,
    output logic          match_o,
    output logic          fire_o,
    output logic          rpt_clear_o
);

    always_comb begin
        match_o     = (instr_i == OPC);
        fire_o      = exec_i && match_o;
        // The compare is not repeatable: kill any active repeat.
        rpt_clear_o = fire_o && rpt_active_i;
    end

endmodule

// File: rtl/cmpf_shifter.sv
module cmpf_shifter
    import cmpf_pkg::*;
#(
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned MW   = MODE_W,
    parameter int unsigned NLSH = MAX_LSH,
    parameter int unsigned NRSH = MAX_RSH
) (
    input  logic [DW-1:0] data_i,
    input  logic [MW-1:0] mode_i,
    output logic [DW-1:0] data_o
);

    localparam int unsigned NCAND = NLSH + NRSH + 1;

    logic [DW-1:0] cand_l [0:NLSH];
    logic [DW-1:0] cand_r [1:NRSH];
    shift_kind_e   kind;

    genvar gl;
    generate
        for (gl = 0; gl <= int'(NLSH); gl++) begin : g_lsh
            assign cand_l[gl] = data_i << gl;
        end
    endgenerate

    genvar gr;
    generate
        for (gr = 1; gr <= int'(NRSH); gr++) begin : g_rsh
            assign cand_r[gr] = $unsigned($signed(data_i) >>> gr);
        end
    endgenerate

    always_comb begin
        int m;
        m      = int'($signed(mode_i));
        kind   = classify_mode($signed(mode_i));
        data_o = data_i;
        unique case (kind)
            SH_LEFT: begin
                for (int k = 1; k <= int'(NLSH); k++)
                    if (m == k) data_o = cand_l[k];
            end
            SH_RIGHT: begin
                for (int k = 1; k <= int'(NRSH); k++)
                    if (m == -k) data_o = cand_r[k];
            end
            default: data_o = cand_l[0];
        endcase
    end

    initial begin
        if (NCAND > (1 << MW))
            $error("shift range does not fit the mode field");
    end

endmodule

// File: rtl/cmpf_flagcalc.sv
module cmpf_flagcalc
    import cmpf_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    output flags_t        flags_o
);

    localparam int unsigned XW = DW + 1;

    logic [XW-1:0] sdiff;
    logic [XW-1:0] udiff;

    always_comb begin
        // Signed view widened by one bit: its top bit is the exact sign.
        sdiff = {lhs_i[DW-1], lhs_i} - {rhs_i[DW-1], rhs_i};
        // Unsigned view widened by one bit: its top bit is the borrow.
        udiff = {1'b0, lhs_i} - {1'b0, rhs_i};
        flags_o.n = sdiff[XW-1];
        flags_o.z = (udiff[DW-1:0] == '0);
        flags_o.c = ~udiff[XW-1];
    end

endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
    import cmpf_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned MW = MODE_W,
    parameter int unsigned IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] prod_i,
    input  logic [MW-1:0] shift_mode_i,
    input  logic [IW-1:0] instr_i,
    input  logic          exec_i,
    input  logic          rpt_active_i,
    output logic          flag_n_o,
    output logic          flag_z_o,
    output logic          flag_c_o,
    output logic          op_match_o,
    output logic          rpt_clear_o
);

    logic          fire;
    logic [DW-1:0] prod_sh;
    flags_t        next_flags;
    flags_t        flags_q;

    cmpf_decode #(.IW(IW), .OPC(CMP_OPCODE)) u_decode (
        .instr_i      (instr_i),
        .exec_i       (exec_i),
        .rpt_active_i (rpt_active_i),
        .match_o      (op_match_o),
        .fire_o       (fire),
        .rpt_clear_o  (rpt_clear_o)
    );

    cmpf_shifter #(.DW(DW), .MW(MW), .NLSH(MAX_LSH), .NRSH(MAX_RSH)) u_shift (
        .data_i (prod_i),
        .mode_i (shift_mode_i),
        .data_o (prod_sh)
    );

    cmpf_flagcalc #(.DW(DW)) u_calc (
        .lhs_i   (acc_i),
        .rhs_i   (prod_sh),
        .flags_o (next_flags)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= FLAGS_RESET;
        else if (fire)
            flags_q <= next_flags;
    end

    assign flag_n_o = flags_q.n;
    assign flag_z_o = flags_q.z;
    assign flag_c_o = flags_q.c;

endmodule

// File: rtl/cmpf_chk.sv
module cmpf_chk
    import cmpf_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned MW = MODE_W,
    parameter int unsigned IW = INSTR_W
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] prod_i,
    input logic [MW-1:0] shift_mode_i,
    input logic [IW-1:0] instr_i,
    input logic          exec_i,
    input logic          rpt_active_i,
    input logic          flag_n_o,
    input logic          flag_z_o,
    input logic          flag_c_o,
    input logic          op_match_o,
    input logic          rpt_clear_o
);

    // R2
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(exec_i && op_match_o) |=> ($stable(flag_n_o) && $stable(flag_z_o) && $stable(flag_c_o)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!flag_n_o && !flag_z_o && !flag_c_o));

    // R7
    rpt_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_clear_o |-> (exec_i && op_match_o && rpt_active_i));

    // R5
    zero_implies_carry_chk: assert property (@(posedge clk) disable iff (rst)
        flag_z_o |-> (flag_c_o && !flag_n_o));

    // R6
    unshifted_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_match_o && shift_mode_i == '0) |=> (flag_c_o == ($past(acc_i) >= $past(prod_i))));

    // R4
    unshifted_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_match_o && shift_mode_i == '0) |=>
            (flag_n_o == ($signed($past(acc_i)) < $signed($past(prod_i)))));

endmodule

bind cmpf_unit cmpf_chk #(.DW(DW), .MW(MW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_i        (acc_i),
    .prod_i       (prod_i),
    .shift_mode_i (shift_mode_i),
    .instr_i      (instr_i),
    .exec_i       (exec_i),
    .rpt_active_i (rpt_active_i),
    .flag_n_o     (flag_n_o),
    .flag_z_o     (flag_z_o),
    .flag_c_o     (flag_c_o),
    .op_match_o   (op_match_o),
    .rpt_clear_o  (rpt_clear_o)
);

// File: tb/tb_cmpf_unit.sv
module tb_cmpf_unit;

    localparam time CLK_PERIOD = 10;
    localparam logic [15:0] OPC = 16'hFF59;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] acc, prod;
    logic [3:0]  mode;
    logic [15:0] instr;
    logic        exec, rpt;
    logic        fn, fz, fc, match, rclr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpf_unit dut (
        .clk(clk), .rst(rst), .acc_i(acc), .prod_i(prod), .shift_mode_i(mode),
        .instr_i(instr), .exec_i(exec), .rpt_active_i(rpt),
        .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc),
        .op_match_o(match), .rpt_clear_o(rclr)
    );

    typedef struct {
        logic  n;
        logic  z;
        logic  c;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic en = 0, ez = 0, ec = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_shift(input logic [31:0] p, input logic [3:0] m);
        int k;
        k = int'($signed(m));
        if (k >= 0 && k <= 4) return p << k;
        if (k < 0 && k >= -6) return $unsigned($signed(p) >>> (-k));
        return p;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] p, input logic [3:0] m,
                         input logic [15:0] ins, input logic ex, input logic rp, input string tag);
        logic [31:0] sh;
        longint diff;
        @(negedge clk);
        acc = a; prod = p; mode = m; instr = ins; exec = ex; rpt = rp;
        #1;
        check("R1", "op_match", 32'(match), 32'(ins == OPC));
        check("R7", "rpt_clear", 32'(rclr), 32'(ex && rp && ins == OPC));
        if (ex && ins == OPC) begin
            sh   = ref_shift(p, m);
            diff = longint'($signed(a)) - longint'($signed(sh));
            en   = (diff < 0);
            ez   = (a == sh);
            ec   = (a >= sh);
        end
        q.push_back('{n: en, z: ez, c: ec, tag: tag});
    endtask

    // Monitor: compare flags just after each edge against the queued model.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (!rst && q.size() > 0) begin
                e = q.pop_front();
                check(e.tag, "flag_n", 32'(fn), 32'(e.n));
                check(e.tag, "flag_z", 32'(fz), 32'(e.z));
                check(e.tag, "flag_c", 32'(fc), 32'(e.c));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; exec = 1'b0; rpt = 1'b0;
        @(negedge clk);
        check("R8", "flag_n", 32'(fn), 32'd0);
        check("R8", "flag_z", 32'(fz), 32'd0);
        check("R8", "flag_c", 32'(fc), 32'd0);
        rst = 1'b0;
        en = 0; ez = 0; ec = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc = '0; prod = '0; mode = '0; instr = '0; exec = 1'b0; rpt = 1'b0;
        repeat (2) @(negedge clk);
        // R8 reset state
        check("R8", "flag_n", 32'(fn), 32'd0);
        check("R8", "flag_z", 32'(fz), 32'd0);
        check("R8", "flag_c", 32'(fc), 32'd0);
        rst = 1'b0;

        // R5 equal operands
        drive(32'h1234_5678, 32'h1234_5678, 4'd0, OPC, 1, 0, "R5");
        // R4 infinite-precision sign: most negative minus one
        drive(32'h8000_0000, 32'h0000_0001, 4'd0, OPC, 1, 0, "R4");
        // R6 borrow case: 1 - 2
        drive(32'h0000_0001, 32'h0000_0002, 4'd0, OPC, 1, 0, "R6");
        // R4/R6 positive signed difference but unsigned borrow
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd0, OPC, 1, 0, "R4");
        // R4 max positive minus most negative: wraps in 32 bits
        drive(32'h7FFF_FFFF, 32'h8000_0000, 4'd0, OPC, 1, 0, "R4");

        // R3 every mode encoding with a value exposing fill behaviour
        for (int m = 0; m < 16; m++) begin
            drive(32'h0800_0000, 32'h8000_0F0F, 4'(m), OPC, 1, 0, "R3");
            drive(ref_shift(32'hC3A5_0F0F, 4'(m)), 32'hC3A5_0F0F, 4'(m), OPC, 1, 0, "R3");
        end

        // R2 non-matching opcode with execute: hold
        drive(32'h0000_0005, 32'h0000_0009, 4'd0, OPC, 1, 0, "R2");
        drive(32'h0000_0009, 32'h0000_0009, 4'd0, 16'hFF58, 1, 0, "R2");
        // R2 matching opcode without execute: hold
        drive(32'h0000_0009, 32'h0000_0009, 4'd0, OPC, 0, 0, "R2");
        drive(32'h0000_0000, 32'hFFFF_FFFF, 4'd0, 16'h0000, 1, 1, "R2");

        // R7 repeat active with compare: clear plus single update
        drive(32'h0000_0040, 32'h0000_0004, 4'd4, OPC, 1, 1, "R7");
        drive(32'h0000_0001, 32'h0000_0040, 4'd0, OPC, 0, 1, "R7");
        drive(32'h0000_0001, 32'h0000_0040, 4'd0, 16'hFF5A, 1, 1, "R7");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 4'hF, OPC, 1, 1, "R7");

        // R8 mid-run reset after flags set
        drive(32'h8000_0000, 32'h0000_0001, 4'd0, OPC, 1, 0, "R4");
        @(negedge clk);
        do_reset();

        // Mixed stimulus
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, p;
            logic [3:0]  m;
            logic [15:0] ins;
            a   = $urandom;
            p   = $urandom;
            m   = 4'($urandom_range(0, 15));
            ins = ($urandom_range(0, 3) != 0) ? OPC : 16'($urandom);
            if (i % 7 == 0) a = ref_shift(p, m);
            drive(a, p, m, ins, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule